// File: doc/BRIEF.md
# SPI Flash Identification Responder

This block is the device-side logic that lets a serial flash answer an identification query. It watches a chip-select line (active low), a serial clock and a serial data input. These are oversampled by the chip's system clock. While chip-select is low, it shifts in an 8-bit command, most significant bit first, on rising serial-clock edges. If the command is the identification code 0x9F, it returns a fixed five-byte answer on a serial output. It then releases that output.

The serial output is modelled as a data bit with a separate output-enable. The enable stands for the tri-state control of the pad. The answer bytes are parameters and are sent in this order:

1. a manufacturer code
2. the first device byte
3. the second device byte
4. a length byte fixed at 0x01, meaning one extended byte follows
5. the one extended byte

Bits are driven in SPI mode 0: each bit is put out on a falling serial-clock edge, so the host can sample it on the next rising edge.

Any other command keeps the output off. Releasing chip-select at any moment ends the operation at once. Every new chip-select assertion starts a fresh command.

Top module: `spi_id_responder`

## Requirements
- R1: While `rstN` is low, and whenever `csN` is high, `soEn` is 0.
- R2: After `csN` falls, the first eight rising `sck` edges sample `si` as the command, most significant bit first. Only the value 0x9F starts a response.
- R3: After the 9F command, `soEn` becomes 1 on the falling `sck` edge that follows the eighth rising edge. At that point `soData` carries bit 7 of the manufacturer code.
- R4: The response is 40 bits long, most significant bit first within each byte. The bytes are, in order: `MFR_ID`, `DEV_ID_HI`, `DEV_ID_LO`, 0x01, `EXT_BYTE`. `soData` changes only while `sck` is low.
- R5: After the 40th response bit, `soEn` returns to 0 on the next falling `sck` edge. It stays 0 for any further `sck` cycles until `csN` is raised.
- R6: Any command other than 0x9F leaves `soEn` at 0 for the rest of that chip-select period.
- R7: Raising `csN` at any point, including partway through a command or response byte, forces `soEn` to 0 in the same cycle.
- R8: A chip-select release partway through a command or response clears all progress. The next assertion decodes a new command from its first bit.
- R9: `si` is ignored during the response. Changing it does not alter the response bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| soData | output | 1 | Serial response data bit |
| soEn | output | 1 | Output enable for the serial response pad |

## Verification
The checker assumes that `sck`, `csN` and `si` are already synchronous to `clk`. It also assumes each `sck` level lasts several `clk` cycles, so every serial edge is seen and the output settles while `sck` is still low. The bench drives all inputs on falling `clk` edges and holds each `sck` phase for four `clk` cycles. It also leaves a few `clk` cycles between a `csN` change and the next serial edge. Within those limits, every output change the assertions allow falls inside a low `sck` phase.

// File: rtl/spiid_pkg.sv
package spiid_pkg;

  typedef enum logic [1:0] {
    ST_CMD    = 2'd0,
    ST_RESP   = 2'd1,
    ST_DONE   = 2'd2,
    ST_REJECT = 2'd3
  } spiidState_e;

  typedef struct packed {
    logic clear;
    logic shiftIn;
    logic loadNext;
    logic shiftOut;
  } spiidStrobe_t;

endpackage

// File: rtl/spiid_datapath.sv
module spiid_datapath
  import spiid_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned IDX_W    = 3,
  parameter logic [7:0]  ID_CMD   = 8'h9F,
  parameter logic [7:0]  MFR_ID   = 8'hA5,
  parameter logic [7:0]  DEV_HI   = 8'h3C,
  parameter logic [7:0]  DEV_LO   = 8'h07,
  parameter logic [7:0]  EXT_BYTE = 8'h5A
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             si,
  input  spiidStrobe_t     strb,
  input  logic [IDX_W-1:0] byteSel,
  output logic             opMatch,
  output logic             soBit
);

  localparam logic [BYTE_W-1:0] EXT_LEN = BYTE_W'(1);

  logic              siQ;
  logic [BYTE_W-1:0] cmdReg;
  logic [BYTE_W-1:0] outReg;
  logic [BYTE_W-1:0] nextByte;

  always_comb begin
    case (byteSel)
      IDX_W'(0): nextByte = MFR_ID;
      IDX_W'(1): nextByte = DEV_HI;
      IDX_W'(2): nextByte = DEV_LO;
      IDX_W'(3): nextByte = EXT_LEN;
      default:   nextByte = EXT_BYTE;
    endcase
  end

  assign opMatch = ({cmdReg[BYTE_W-2:0], siQ} == ID_CMD);
  assign soBit   = outReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      siQ    <= 1'b0;
      cmdReg <= '0;
      outReg <= '0;
    end else begin
      siQ <= si;
      if (strb.clear) begin
        cmdReg <= '0;
        outReg <= '0;
      end else begin
        if (strb.shiftIn)  cmdReg <= {cmdReg[BYTE_W-2:0], siQ};
        if (strb.loadNext) outReg <= nextByte;
        else if (strb.shiftOut) outReg <= {outReg[BYTE_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spiid_ctrl.sv
module spiid_ctrl
  import spiid_pkg::*;
#(
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned RESP_BYTES = 5,
  parameter int unsigned IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sck,
  input  logic             csN,
  input  logic             opMatch,
  output spiidStrobe_t     strb,
  output logic [IDX_W-1:0] byteSel,
  output logic             driving
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RESP_BYTES - 1);

  spiidState_e      state;
  logic             sckQ, sckPrev, csQ;
  logic             sckRise, sckFall;
  logic [CNT_W-1:0] bitCnt;
  logic [IDX_W-1:0] byteIdx;

  assign sckRise = sckQ & ~sckPrev;
  assign sckFall = ~sckQ & sckPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ    <= 1'b0;
      sckPrev <= 1'b0;
      csQ     <= 1'b1;
    end else begin
      sckQ    <= sck;
      sckPrev <= sckQ;
      csQ     <= csN;
    end
  end

  always_comb begin
    strb    = '0;
    byteSel = byteIdx;
    if (csQ) begin
      strb.clear = 1'b1;
    end else begin
      case (state)
        ST_CMD: if (sckRise) begin
          strb.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT && opMatch) begin
            strb.loadNext = 1'b1;
            byteSel       = '0;
          end
        end
        ST_RESP: if (sckFall && driving) begin
          if (bitCnt == LAST_BIT) begin
            if (byteIdx != LAST_IDX) begin
              strb.loadNext = 1'b1;
              byteSel       = byteIdx + IDX_W'(1);
            end
          end else begin
            strb.shiftOut = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_CMD;
      bitCnt  <= '0;
      byteIdx <= '0;
      driving <= 1'b0;
    end else if (csQ) begin
      state   <= ST_CMD;
      bitCnt  <= '0;
      byteIdx <= '0;
      driving <= 1'b0;
    end else begin
      case (state)
        ST_CMD: if (sckRise) begin
          if (bitCnt == LAST_BIT) begin
            bitCnt <= '0;
            state  <= opMatch ? ST_RESP : ST_REJECT;
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        ST_RESP: if (sckFall) begin
          if (!driving) begin
            driving <= 1'b1;
          end else if (bitCnt == LAST_BIT) begin
            bitCnt <= '0;
            if (byteIdx == LAST_IDX) begin
              state   <= ST_DONE;
              driving <= 1'b0;
            end else begin
              byteIdx <= byteIdx + IDX_W'(1);
            end
          end else begin
            bitCnt <= bitCnt + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
  import spiid_pkg::*;
#(
  parameter logic [7:0] ID_CMD    = 8'h9F,
  parameter logic [7:0] MFR_ID    = 8'hA5,
  parameter logic [7:0] DEV_ID_HI = 8'h3C,
  parameter logic [7:0] DEV_ID_LO = 8'h07,
  parameter logic [7:0] EXT_BYTE  = 8'h5A
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  output logic soData,
  output logic soEn
);

  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned RESP_BYTES = 5;
  localparam int unsigned IDX_W      = $clog2(RESP_BYTES);

  spiidStrobe_t     strb;
  logic [IDX_W-1:0] byteSel;
  logic             opMatch;
  logic             soBit;
  logic             driving;

  spiid_ctrl #(
    .BYTE_W(BYTE_W), .RESP_BYTES(RESP_BYTES), .IDX_W(IDX_W)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .opMatch(opMatch),
    .strb(strb), .byteSel(byteSel), .driving(driving)
  );

  spiid_datapath #(
    .BYTE_W(BYTE_W), .IDX_W(IDX_W), .ID_CMD(ID_CMD), .MFR_ID(MFR_ID),
    .DEV_HI(DEV_ID_HI), .DEV_LO(DEV_ID_LO), .EXT_BYTE(EXT_BYTE)
  ) dpI (
    .clk(clk), .rstN(rstN), .si(si), .strb(strb), .byteSel(byteSel),
    .opMatch(opMatch), .soBit(soBit)
  );

  assign soEn   = driving & ~csN;
  assign soData = soEn & soBit;

endmodule

// File: rtl/spi_id_responder_chk.sv
module spi_id_responder_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sck,
  input logic soData,
  input logic soEn
);

  // R1
  cs_idle_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !soEn);

  // R7
  cs_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> !soEn);

  // R3
  start_low_sck_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(soEn) |-> !sck);

  // R4
  data_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (soEn && $past(soEn) && (soData != $past(soData))) |-> !sck);

  // R5
  release_low_sck_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(soEn) && !csN) |-> !sck);

endmodule

bind spi_id_responder spi_id_responder_chk chkI (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .soData(soData), .soEn(soEn)
);

// File: tb/tb_spi_id_responder.sv
module tb_spi_id_responder;

  localparam logic [7:0] MFR  = 8'hA5;
  localparam logic [7:0] DVH  = 8'h3C;
  localparam logic [7:0] DVL  = 8'h07;
  localparam logic [7:0] EXTB = 8'h5A;
  localparam int NVEC = 5;
  // {command, si pattern during response, response expected}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h9F, 8'h00, 1'b1},
    {8'h9F, 8'hFF, 1'b1},
    {8'h9E, 8'h00, 1'b0},
    {8'h1F, 8'hA5, 1'b0},
    {8'hFF, 8'hFF, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic soData, soEn;

  int nChecks = 0;
  int nFails = 0;
  logic sEn, sData;
  logic cmdEnAny, firstEn, firstBit;
  logic [7:0] gotByte [8];
  logic enAll [8];
  logic enAny [8];
  logic [7:0] expByte [5];

  always #5 clk = ~clk;

  spi_id_responder dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si),
    .soData(soData), .soEn(soEn)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sckCycle(input logic siVal);
    si = siVal;
    repeat (4) @(negedge clk);
    sEn = soEn;
    sData = soData;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] op);
    csN = 1'b0;
    repeat (4) @(negedge clk);
    cmdEnAny = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sckCycle(op[i]);
      cmdEnAny |= sEn;
    end
  endtask

  task automatic readBytes(input logic [7:0] noise, input int nb);
    for (int b = 0; b < nb; b++) begin
      enAll[b] = 1'b1;
      enAny[b] = 1'b0;
      for (int i = 7; i >= 0; i--) begin
        sckCycle(noise[i]);
        if (b == 0 && i == 7) begin
          firstEn = sEn;
          firstBit = sData;
        end
        gotByte[b][i] = sData;
        enAll[b] &= sEn;
        enAny[b] |= sEn;
      end
    end
  endtask

  task automatic csRelease();
    csN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic checkFull(input string tag);
    for (int b = 0; b < 5; b++) begin
      chk(enAll[b], {tag, " enable held"}, 32'(enAll[b]), 32'd1);
      chk(gotByte[b] == expByte[b], {tag, " byte value"}, 32'(gotByte[b]), 32'(expByte[b]));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    expByte[0] = MFR; expByte[1] = DVH; expByte[2] = DVL;
    expByte[3] = 8'h01; expByte[4] = EXTB;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(soEn == 1'b0, "R1 reset", 32'(soEn), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1: sck toggling with csN high
    for (int i = 0; i < 8; i++) begin
      sckCycle(1'b1);
      chk(sEn == 1'b0, "R1 cs high", 32'(sEn), 32'd0);
    end

    // Table walk: R2 R4 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      sendCmd(VEC[v][16:9]);
      chk(cmdEnAny == 1'b0, "R2 off during command", 32'(cmdEnAny), 32'd0);
      readBytes(VEC[v][8:1], 6);
      if (VEC[v][0]) begin
        checkFull("R4/R9 response");
        chk(enAny[5] == 1'b0, "R5 released after last", 32'(enAny[5]), 32'd0);
      end else begin
        for (int b = 0; b < 6; b++)
          chk(enAny[b] == 1'b0, "R6 bad command silent", 32'(enAny[b]), 32'd0);
      end
      csRelease();
    end

    // R3: first bit timing and value
    sendCmd(8'h9F);
    readBytes(8'h00, 1);
    chk(firstEn == 1'b1, "R3 first bit enabled", 32'(firstEn), 32'd1);
    chk(firstBit == MFR[7], "R3 first bit value", 32'(firstBit), 32'(MFR[7]));
    csRelease();

    // R5: many extra clocks after response
    sendCmd(8'h9F);
    readBytes(8'h3C, 8);
    checkFull("R5 prefix");
    chk(enAny[5] == 1'b0 && enAny[6] == 1'b0 && enAny[7] == 1'b0,
        "R5 stays released", 32'({enAny[5], enAny[6], enAny[7]}), 32'd0);
    csRelease();

    // R7: abort partway through a response byte
    sendCmd(8'h9F);
    readBytes(8'h00, 1);
    for (int i = 0; i < 3; i++) sckCycle(1'b0);
    chk(soEn == 1'b1, "R7 driving before abort", 32'(soEn), 32'd1);
    csN = 1'b1;
    #1;
    chk(soEn == 1'b0, "R7 immediate release", 32'(soEn), 32'd0);
    repeat (4) @(negedge clk);

    // R8: fresh response after a mid-byte abort
    sendCmd(8'h9F);
    readBytes(8'h00, 5);
    checkFull("R8 after response abort");
    csRelease();

    // R8: abort partway through the command, then a fresh command
    csN = 1'b0;
    repeat (4) @(negedge clk);
    sckCycle(1'b1); sckCycle(1'b0); sckCycle(1'b0); sckCycle(1'b1);
    csRelease();
    sendCmd(8'h9F);
    readBytes(8'h00, 6);
    checkFull("R8 after command abort");
    chk(enAny[5] == 1'b0, "R8 release", 32'(enAny[5]), 32'd0);
    csRelease();

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule